// File: doc/BRIEF.md
# Masked Status and Dual Interrupt Unit

This block is the status and interrupt corner of a memory-card host controller. It keeps a 22-bit status word. The low 11 bits are sticky event flags: producers elsewhere set them with one-cycle pulses, and software clears them with a write-one-to-clear access. The upper 11 bits mirror live FIFO condition flags that the transfer engine drives. Each of two 32-bit mask registers selects which status bits raise its own level interrupt line.

The same register path also serves several other registers. It has an 8-bit power register and an 8-bit clock register. It has a read-only FIFO word count, taken from the remaining byte count. It has a window of identification bytes. Reads of the FIFO data window pass a word through from the external FIFO and pop it.

Each such read also arms a refill hold-off. While the hold-off is set, the card-to-FIFO engine does not refill the FIFO. The hold-off stays set until software reads the status register or the word-count register. That read releases it and sends a one-cycle restart pulse to the engine.

Top module: `stat_irq_unit`

## Requirements
- R1: After reset the status word, both masks, the power and clock registers, the hold-off flag, the restart pulse and both interrupt lines are all zero.
- R2: A one-cycle pulse on bit k of `evt_set` (k in 0..10) sets status bit k at the next clock edge. The bit then stays set until it is cleared.
- R3: Status bits 21:11 follow `fifo_flags[10:0]` with a delay of one clock. No register access can set or clear them.
- R4: A write to offset 0x38 clears each status bit k for which `reg_wdata[k]` is 1 (k in 0..10). Data bits 31:11 of that write have no effect. If a set pulse and a clear hit the same bit in the same cycle, the bit ends up set. A read of 0x38 returns zero.
- R5: There are two mask registers, mask 0 at 0x3C and mask 1 at 0x40. Each holds all 32 written bits. `irq[k]` is high one cycle after the AND of the status word and mask k is nonzero. Mask bits 31:22 never raise an interrupt.
- R6: A read takes effect at the clock edge where `reg_rd` is high, and `reg_rdata` holds the result from that edge on. A status read at 0x34 returns the status word as it stood before that edge.
- R7: A read of 0x48 returns (`byte_cnt` + 3) >> 2, which is the number of 32-bit words still to move.
- R8: A read of a word-aligned offset from 0x80 to 0xBC returns `fifo_word`. In the same cycle it raises `fifo_pop`, and it sets `refill_hold` at that edge. Unaligned offsets in that range are unmapped.
- R9: A read of 0x34 or 0x48 clears `refill_hold`. If the hold-off was set, `refill_kick` is high for exactly the one cycle after that read edge. Otherwise `refill_kick` stays low.
- R10: Word-aligned reads at 0xFE0, 0xFE4, and so on up to 0xFFC return, in that order, the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with zeros above.
- R11: The power register (0x00) and the clock register (0x04) keep only bits 7:0 of a write, and read back with zeros above bit 7.
- R12: Reads of unmapped offsets return zero and cause no pop and no hold-off. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_set | input | 11 | Set pulses for sticky status bits 10:0 |
| fifo_flags | input | 11 | Live FIFO flags mirrored into status bits 21:11 |
| byte_cnt | input | 16 | Remaining transfer byte count |
| fifo_word | input | 32 | Head word of the data FIFO |
| fifo_pop | output | 1 | Pop request for the data FIFO |
| refill_hold | output | 1 | Hold-off flag that blocks card-to-FIFO refill |
| refill_kick | output | 1 | One-cycle pulse that restarts the refill engine |
| irq | output | 2 | Level interrupt lines, one per mask |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high in the same cycle. They also assume that `fifo_flags` and `evt_set` are driven to known values at every clock edge after reset. The stimulus drives every input only on the falling edge and issues exactly one access per task call. It holds `evt_set` high for exactly one cycle, either on its own or together with a single clear write so as to test which one wins. Because of this, every status or interrupt check lands on a cycle whose cause is fixed.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_POWER  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CLOCK  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h038;
  localparam logic [ADDR_W-1:0] OFS_MASK0  = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_WIN_LO = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_WIN_HI = 12'h0BC;
  localparam logic [ADDR_W-1:0] OFS_ID_LO  = 12'hFE0;

  // Words still to move for a remaining byte count (round up).
  function automatic logic [31:0] words_left(input logic [31:0] bytes);
    return (bytes + 32'd3) >> 2;
  endfunction

  // Identification byte for slot 0..7.
  function automatic logic [7:0] id_byte(input logic [2:0] slot);
    case (slot)
      3'd0:    return 8'h81;
      3'd1:    return 8'h11;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  function automatic logic in_fifo_window(input logic [ADDR_W-1:0] a);
    return (a >= OFS_WIN_LO) && (a <= OFS_WIN_HI) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic in_id_window(input logic [ADDR_W-1:0] a);
    return (a >= OFS_ID_LO) && (a[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/stat_irq_status.sv
module stat_irq_status #(
  parameter int STAT_W   = 22,
  parameter int STATIC_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [STATIC_W-1:0]        set_pulse,
  input  logic [STAT_W-STATIC_W-1:0] dyn_flags,
  input  logic                       clr_en,
  input  logic [STATIC_W-1:0]        clr_bits,
  output logic [STAT_W-1:0]          status_q
);
  localparam int DYN_W = STAT_W - STATIC_W;

  logic [STATIC_W-1:0] sticky_q;
  logic [DYN_W-1:0]    dyn_q;
  logic [STATIC_W-1:0] clr_eff;

  assign clr_eff = clr_en ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      dyn_q    <= '0;
    end else begin
      sticky_q <= (sticky_q & ~clr_eff) | set_pulse;
      dyn_q    <= dyn_flags;
    end
  end

  assign status_q = {dyn_q, sticky_q};
endmodule

// File: rtl/stat_irq_line.sv
module stat_irq_line #(
  parameter int DATA_W = 32,
  parameter int STAT_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0] status,
  output logic [DATA_W-1:0] mask_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] status_ext;
  logic              hit;

  assign status_ext = DATA_W'(status);
  assign hit        = |(status_ext & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= wdata;
      irq_q <= hit;
    end
  end
endmodule

// File: rtl/stat_irq_holdoff.sv
module stat_irq_holdoff (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic release_req,
  output logic hold_q,
  output logic kick_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= release_req & hold_q;
      if (arm)              hold_q <= 1'b1;
      else if (release_req) hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_irq_unit.sv
module stat_irq_unit
  import stat_irq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 22,
  parameter int STATIC_W = 11,
  parameter int CNT_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int NUM_IRQ  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [11:0]                reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [STATIC_W-1:0]        evt_set,
  input  logic [STAT_W-STATIC_W-1:0] fifo_flags,
  input  logic [CNT_W-1:0]           byte_cnt,
  input  logic [DATA_W-1:0]          fifo_word,
  output logic                       fifo_pop,
  output logic                       refill_hold,
  output logic                       refill_kick,
  output logic [NUM_IRQ-1:0]         irq
);
  localparam int MASK_STRIDE = 4;

  // Named internal events, also used by the bound checker.
  logic                wr_clear;
  logic                rd_window;
  logic                rd_release;
  logic [STAT_W-1:0]   status_q;
  logic [DATA_W-1:0]   mask_q [NUM_IRQ];
  logic [NUM_IRQ-1:0]  mask_wr;
  logic [BYTE_W-1:0]   power_q;
  logic [BYTE_W-1:0]   clock_q;
  logic [DATA_W-1:0]   rd_val;

  assign wr_clear   = reg_wr && (reg_addr == OFS_CLEAR);
  assign rd_window  = reg_rd && in_fifo_window(reg_addr);
  assign rd_release = reg_rd && ((reg_addr == OFS_STATUS) || (reg_addr == OFS_COUNT));
  assign fifo_pop   = rd_window;

  stat_irq_status #(
    .STAT_W   (STAT_W),
    .STATIC_W (STATIC_W)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (evt_set),
    .dyn_flags (fifo_flags),
    .clr_en    (wr_clear),
    .clr_bits  (reg_wdata[STATIC_W-1:0]),
    .status_q  (status_q)
  );

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    assign mask_wr[k] = reg_wr && (reg_addr == OFS_MASK0 + 12'(MASK_STRIDE * k));
    stat_irq_line #(
      .DATA_W (DATA_W),
      .STAT_W (STAT_W)
    ) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_wr (mask_wr[k]),
      .wdata   (reg_wdata),
      .status  (status_q),
      .mask_q  (mask_q[k]),
      .irq_q   (irq[k])
    );
  end

  stat_irq_holdoff u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (rd_window),
    .release_req (rd_release),
    .hold_q      (refill_hold),
    .kick_q      (refill_kick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      power_q <= '0;
      clock_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_POWER) power_q <= reg_wdata[BYTE_W-1:0];
      if (reg_addr == OFS_CLOCK) clock_q <= reg_wdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_id_window(reg_addr)) begin
      rd_val = DATA_W'(id_byte(reg_addr[4:2]));
    end else if (in_fifo_window(reg_addr)) begin
      rd_val = fifo_word;
    end else if (reg_addr == OFS_POWER) begin
      rd_val = DATA_W'(power_q);
    end else if (reg_addr == OFS_CLOCK) begin
      rd_val = DATA_W'(clock_q);
    end else if (reg_addr == OFS_STATUS) begin
      rd_val = DATA_W'(status_q);
    end else if (reg_addr == OFS_COUNT) begin
      rd_val = DATA_W'(words_left(32'(byte_cnt)));
    end else begin
      for (int k = 0; k < NUM_IRQ; k++) begin
        if (reg_addr == OFS_MASK0 + 12'(MASK_STRIDE * k)) rd_val = mask_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/stat_irq_unit_chk.sv
module stat_irq_unit_chk
  import stat_irq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 22,
  parameter int STATIC_W = 11,
  parameter int NUM_IRQ  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic                       reg_rd,
  input logic [11:0]                reg_addr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic [STATIC_W-1:0]        evt_set,
  input logic [STAT_W-STATIC_W-1:0] fifo_flags,
  input logic [STAT_W-1:0]          status_q,
  input logic [DATA_W-1:0]          mask_q [NUM_IRQ],
  input logic                       refill_hold,
  input logic                       refill_kick,
  input logic [NUM_IRQ-1:0]         irq
);
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_chk
    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (irq[k] == $past(|(DATA_W'(status_q) & mask_q[k]))));
  end

  assert_dyn_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status_q[STAT_W-1:STATIC_W] == $past(fifo_flags)));

  assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CLEAR) |=>
      ((status_q[STATIC_W-1:0] & $past(reg_wdata[STATIC_W-1:0] & ~evt_set)) == '0));

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((status_q[STATIC_W-1:0] & $past(evt_set)) == $past(evt_set)));

  assert_window_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && in_fifo_window(reg_addr)) |=> refill_hold);

  assert_release_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == OFS_STATUS || reg_addr == OFS_COUNT)) |=> !refill_hold);

  assert_kick_needs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    refill_kick |-> $past(refill_hold));
endmodule

bind stat_irq_unit stat_irq_unit_chk #(
  .DATA_W   (DATA_W),
  .STAT_W   (STAT_W),
  .STATIC_W (STATIC_W),
  .NUM_IRQ  (NUM_IRQ)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .evt_set     (evt_set),
  .fifo_flags  (fifo_flags),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .refill_hold (refill_hold),
  .refill_kick (refill_kick),
  .irq         (irq)
);

// File: tb/stat_irq_unit_tb.sv
module stat_irq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [10:0] evt_set = '0;
  logic [10:0] fifo_flags = '0;
  logic [15:0] byte_cnt = '0;
  logic [31:0] fifo_word = '0;
  logic        fifo_pop;
  logic        refill_hold;
  logic        refill_kick;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  int pops = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_set(evt_set), .fifo_flags(fifo_flags), .byte_cnt(byte_cnt),
    .fifo_word(fifo_word), .fifo_pop(fifo_pop), .refill_hold(refill_hold),
    .refill_kick(refill_kick), .irq(irq)
  );

  always @(posedge clk) if (fifo_pop) pops++;

  // {is_write, offset, data}; for reads data is the expected value.
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1, 12'h000, 32'h1234_56AB}, {1'b0, 12'h000, 32'h0000_00AB},
    {1'b1, 12'h004, 32'hFFFF_FF5C}, {1'b0, 12'h004, 32'h0000_005C},
    {1'b1, 12'h03C, 32'hDEAD_BEEF}, {1'b0, 12'h03C, 32'hDEAD_BEEF},
    {1'b1, 12'h040, 32'h0000_0F0F}, {1'b0, 12'h040, 32'h0000_0F0F},
    {1'b0, 12'hFE0, 32'h0000_0081}, {1'b0, 12'hFE4, 32'h0000_0011},
    {1'b0, 12'hFE8, 32'h0000_0004}, {1'b0, 12'hFEC, 32'h0000_0000},
    {1'b0, 12'hFF0, 32'h0000_000D}, {1'b0, 12'hFF4, 32'h0000_00F0},
    {1'b0, 12'hFF8, 32'h0000_0005}, {1'b0, 12'hFFC, 32'h0000_00B1},
    {1'b1, 12'h010, 32'hFFFF_FFFF}, {1'b0, 12'h010, 32'h0000_0000},
    {1'b0, 12'h038, 32'h0000_0000}, {1'b0, 12'h044, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] stat_of(input logic [10:0] dyn, input logic [10:0] sticky);
    return {10'b0, dyn, sticky};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int pops0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 hold", 32'(refill_hold), 32'h0);
    do_rd(12'h034, d); check("R1 status", d, 32'h0);
    do_rd(12'h03C, d); check("R1 mask0", d, 32'h0);

    // Table walk: R5 mask readback, R10 id bytes, R11 power/clock, R12 unmapped
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][44]) do_wr(VEC[i][43:32], VEC[i][31:0]);
      else begin
        do_rd(VEC[i][43:32], d);
        check($sformatf("R5/R10/R11/R12 vec%0d", i), d, VEC[i][31:0]);
      end
    end
    do_wr(12'h03C, 32'h0);
    do_wr(12'h040, 32'h0);

    // R2: sticky set pulse
    fifo_flags = 11'h5A5;
    @(negedge clk); evt_set = 11'h040;
    @(negedge clk); evt_set = '0;
    do_rd(12'h034, d); check("R2/R6 status after set", d, stat_of(11'h5A5, 11'h040));
    check("R5 no irq with zero mask", 32'(irq), 32'h0);

    // R5: mask 0 raises irq[0] only
    do_wr(12'h03C, 32'h0000_0040);
    do_rd(12'h034, d);
    check("R5 irq0 high", 32'(irq), 32'h1);

    // R4: clear ignores bits above 10
    do_wr(12'h038, 32'hFFFF_FFFF);
    do_rd(12'h034, d); check("R4 clear low bits only", d, stat_of(11'h5A5, 11'h000));
    check("R5 irq0 drops after clear", 32'(irq), 32'h0);

    // R4: set wins over clear in the same cycle
    @(negedge clk);
    evt_set = 11'h008; reg_wr = 1'b1; reg_addr = 12'h038; reg_wdata = 32'h0000_0008;
    @(negedge clk);
    evt_set = '0; reg_wr = 1'b0; reg_wdata = '0;
    do_rd(12'h038, d); check("R4 clear reads zero", d, 32'h0);
    fifo_flags = 11'h000;
    do_rd(12'h034, d); check("R4/R3 set beats clear", d, stat_of(11'h000, 11'h008));

    // R3/R5: dynamic bit into mask 1; mask bits above 21 inert
    fifo_flags = 11'h001;
    do_wr(12'h040, 32'h0000_0800);
    do_rd(12'h034, d); check("R3 dynamic mirror", d, stat_of(11'h001, 11'h008));
    check("R5 irq1 from dynamic bit", 32'(irq), 32'h2);
    do_wr(12'h040, 32'hFFC0_0000);
    do_rd(12'h034, d);
    check("R5 high mask bits inert", 32'(irq), 32'h0);
    do_wr(12'h038, 32'h0000_07FF);
    fifo_flags = 11'h000;

    // R7: word count
    byte_cnt = 16'd0;    do_rd(12'h048, d); check("R7 cnt 0", d, 32'd0);
    byte_cnt = 16'd1;    do_rd(12'h048, d); check("R7 cnt 1", d, 32'd1);
    byte_cnt = 16'd4;    do_rd(12'h048, d); check("R7 cnt 4", d, 32'd1);
    byte_cnt = 16'd5;    do_rd(12'h048, d); check("R7 cnt 5", d, 32'd2);
    byte_cnt = 16'hFFFF; do_rd(12'h048, d); check("R7 cnt max", d, 32'h4000);
    check("R9 no kick without hold", 32'(refill_kick), 32'h0);

    // R8/R9: window read arms, status read releases
    fifo_word = 32'hCAFE_F00D;
    pops0 = pops;
    do_rd(12'h080, d); check("R8 window data", d, 32'hCAFE_F00D);
    check("R8 pop count", 32'(pops - pops0), 32'd1);
    check("R8 hold set", 32'(refill_hold), 32'h1);
    do_rd(12'h0BC, d); check("R8 window end", d, 32'hCAFE_F00D);
    do_rd(12'h034, d);
    check("R9 hold released", 32'(refill_hold), 32'h0);
    check("R9 kick pulse", 32'(refill_kick), 32'h1);
    @(negedge clk);
    check("R9 kick one cycle", 32'(refill_kick), 32'h0);

    do_rd(12'h0A0, d);
    do_rd(12'h048, d);
    check("R9 count read releases", 32'(refill_hold), 32'h0);
    check("R9 count read kicks", 32'(refill_kick), 32'h1);

    // R12: unaligned and out-of-window offsets
    pops0 = pops;
    do_rd(12'h082, d); check("R12 unaligned window", d, 32'h0);
    do_rd(12'h0C0, d); check("R12 past window", d, 32'h0);
    check("R12 no pop", 32'(pops - pops0), 32'd0);
    check("R12 no hold", 32'(refill_hold), 32'h0);

    // R1: reset in mid-run
    do_wr(12'h03C, 32'h0000_0001);
    do_wr(12'h000, 32'h0000_0077);
    do_rd(12'h090, d);
    @(negedge clk); evt_set = 11'h001;
    @(negedge clk); evt_set = '0;
    @(negedge clk);
    check("R1 pre-reset irq0", 32'(irq), 32'h1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq after reset", 32'(irq), 32'h0);
    check("R1 hold after reset", 32'(refill_hold), 32'h0);
    do_rd(12'h034, d); check("R1 status after reset", d, 32'h0);
    do_rd(12'h03C, d); check("R1 mask0 after reset", d, 32'h0);
    do_rd(12'h000, d); check("R1 power after reset", d, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule